// File: doc/BRIEF.md
# Thread Interrupt Presentation Context

This block holds the interrupt presentation state for one processor thread. It keeps three privilege rings, one each for the guest OS, the hypervisor pool and the physical hypervisor. Every ring stores a current priority limit, a pending-priority bit set and an acknowledge counter. Its status byte and most-urgent pending priority are derived from that state. An interrupt router posts a priority into a ring's pending set. The block compares the most urgent pending priority of each ring against that ring's current limit and drives one exception line per ring towards the core.

Software reaches the context through a small memory-mapped port. Reading the acknowledge offset returns the exception class and the accepted priority in one halfword. The same read raises the ring's current priority to the accepted level and retires that pending bit. A separate pool context word carries a valid flag that gates the pool ring. A pull read returns that word and invalidates it. The port is controlled by a two-state machine. In `ST_IDLE` the port accepts a request. A read takes the `IDLE_TO_RESP` transition into `ST_RESP`, where the registered read data is presented for one cycle. The machine then takes `RESP_TO_IDLE` back. A write leaves the machine in `ST_IDLE` (`IDLE_HOLD`).

Top module: `tctx_top`

## Requirements
- R1: After reset every ring's priority limit, pending set and acknowledge counter are zero, the pool context word is zero and all exception lines are low.
- R2: Ring bases are 0x10 (OS, ring 0), 0x20 (pool, ring 1) and 0x30 (physical, ring 2). Byte offsets within a ring are: status 0x0, priority limit 0x1, pending set 0x2, acknowledge counter 0x4, pending priority 0x7. A read is accepted when `req_ready` is high. Its data appears with `rsp_valid` high one cycle after acceptance, and `req_ready` is low in that cycle.
- R3: A post sets bit `post_prio` of the chosen ring's pending set. The pending priority reads as the index of the lowest set bit, or 0xFF when the set is empty.
- R4: Exception line r is high exactly when ring r's pending priority is numerically lower than its priority limit. For the pool ring, the context valid flag must also be set. The status byte reads 0x80 for OS and physical and 0x40 for pool when its line is high, and 0x00 otherwise.
- R5: A read at 0x800 returns the exception class in bits 15:14 (2 physical, 1 pool, 0 none) and a priority in bits 7:0. The physical ring wins over pool. When nothing is pending the class is 0, the priority field is the physical ring's limit, and no state changes.
- R6: An acknowledge copies the ring's pending priority into its limit, clears that pending bit and increments the ring's 8-bit acknowledge counter.
- R7: The priority limit byte is written only when `req_own` is high; other writes to it are ignored. The pending set byte is writable.
- R8: The pool context word at 0x28 is written and read as 32 bits, with bit 31 as the valid flag. A read at 0x828 returns the word and clears bit 31, keeping the identifier bits.
- R9: Offsets 0x3, 0x5 and 0x6 of a ring read zero. Writes to the status, counter and pending-priority bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register offset |
| req_wdata | input | 32 | Write data (bytes use bits 7:0) |
| req_own | input | 1 | Access comes through the thread's own window |
| req_ready | output | 1 | Port can accept a request |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| post_valid | input | 1 | Router posts a pending priority |
| post_ring | input | 2 | Target ring index 0..2 |
| post_prio | input | 3 | Posted priority 0..7 |
| exc_o | output | 3 | Per-ring exception lines |

## Verification
The bench aims at the strict comparison. A pending priority equal to the limit must stay silent, and a design using less-or-equal would raise the line and report a status bit. It acknowledges twice in a row to catch a design that clears the wrong pending bit or fails to raise the limit. With such a fault the second acknowledge would return a stale priority. It also covers the empty acknowledge, which must leave the counter alone. It checks a pulled or never-valid pool context, whose pending work must not appear in the acknowledge. It checks the physical-over-pool arbitration and a priority write from a foreign window, which must leave the limit unchanged.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
    typedef enum logic [1:0] {
        XT_NONE = 2'd0,
        XT_POOL = 2'd1,
        XT_PHYS = 2'd2,
        XT_LSI  = 2'd3
    } exc_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } mmio_state_e;

    localparam int RING_OS   = 0;
    localparam int RING_POOL = 1;
    localparam int RING_PHYS = 2;
endpackage

// File: rtl/tctx_prio_enc.sv
module tctx_prio_enc #(
    parameter int NPRIO = 8,
    parameter int PW    = 8
) (
    input  logic [NPRIO-1:0] pend_set,
    output logic [PW-1:0]    lowest
);
    always_comb begin
        lowest = '1;
        for (int i = NPRIO - 1; i >= 0; i--) begin
            if (pend_set[i]) lowest = PW'(i);
        end
    end
endmodule

// File: rtl/tctx_ring.sv
module tctx_ring #(
    parameter int NPRIO = 8,
    parameter int PW    = 8,
    parameter int CNT_W = 8,
    localparam int IW   = $clog2(NPRIO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_we,
    input  logic [PW-1:0]    lim_wd,
    input  logic             set_we,
    input  logic [NPRIO-1:0] set_wd,
    input  logic             post,
    input  logic [IW-1:0]    post_prio,
    input  logic             ack,
    input  logic             gate,
    output logic [PW-1:0]    limit,
    output logic [NPRIO-1:0] pend_set,
    output logic [PW-1:0]    top_prio,
    output logic [CNT_W-1:0] ack_cnt,
    output logic             raise
);
    logic [NPRIO-1:0] set_next;

    tctx_prio_enc #(.NPRIO(NPRIO), .PW(PW)) u_enc (
        .pend_set (pend_set),
        .lowest   (top_prio)
    );

    assign raise = gate && (top_prio < limit);

    always_comb begin
        set_next = set_we ? set_wd : pend_set;
        if (ack) set_next[top_prio[IW-1:0]] = 1'b0;
        if (post) set_next[post_prio] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit    <= '0;
            pend_set <= '0;
            ack_cnt  <= '0;
        end else begin
            pend_set <= set_next;
            if (ack) begin
                limit   <= top_prio;
                ack_cnt <= ack_cnt + 1'b1;
            end else if (lim_we) begin
                limit <= lim_wd;
            end
        end
    end

    // R5: an acknowledge only ever retires a raised ring
    p_ack_raised_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> raise);
    // R6: each acknowledge advances the counter by one
    p_ackcnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ack_cnt == CNT_W'($past(ack_cnt) + 1'b1));
    // R7: limit is held unless written or acknowledged
    p_limit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lim_we && !ack) |=> $stable(limit));
    // R3: empty pending set reports the idle code
    p_empty_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set == '0) |-> (top_prio == '1));
endmodule

// File: rtl/tctx_top.sv
module tctx_top #(
    parameter int NPRIO  = 8,
    parameter int PW     = 8,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int NRING = 3,
    localparam int IW    = $clog2(NPRIO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_own,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              post_valid,
    input  logic [1:0]        post_ring,
    input  logic [IW-1:0]     post_prio,
    output logic [NRING-1:0]  exc_o
);
    import tctx_pkg::*;

    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(12'h800);
    localparam logic [ADDR_W-1:0] A_PULL = ADDR_W'(12'h828);
    localparam logic [ADDR_W-1:0] A_POOL = ADDR_W'(12'h028);

    mmio_state_e state_q, state_d;
    logic        acc, rd_acc, wr_acc;
    logic        ring_hit;
    logic [1:0]  ring_idx;
    logic [3:0]  boff;
    logic [DATA_W-1:0] pool_word;
    logic [DATA_W-1:0] rd_mux;

    logic [PW-1:0]    limit_v  [NRING];
    logic [NPRIO-1:0] pend_v   [NRING];
    logic [PW-1:0]    top_v    [NRING];
    logic [CNT_W-1:0] cnt_v    [NRING];
    logic [NRING-1:0] raise_v;
    logic [NRING-1:0] ack_v;
    logic             is_ack, is_pull;

    assign acc    = req_valid && (state_q == ST_IDLE);
    assign rd_acc = acc && !req_write;
    assign wr_acc = acc && req_write;

    assign ring_hit = (req_addr[ADDR_W-1:6] == '0) && (req_addr[5:4] != 2'd0)
                      && (req_addr[3] == 1'b0);
    assign ring_idx = req_addr[5:4] - 2'd1;
    assign boff     = req_addr[3:0];
    assign is_ack   = rd_acc && (req_addr == A_ACK);
    assign is_pull  = rd_acc && (req_addr == A_PULL);

    // Acknowledge arbitration: physical before pool
    assign ack_v[RING_OS]   = 1'b0;
    assign ack_v[RING_PHYS] = is_ack && raise_v[RING_PHYS];
    assign ack_v[RING_POOL] = is_ack && !raise_v[RING_PHYS] && raise_v[RING_POOL];

    for (genvar r = 0; r < NRING; r++) begin : g_ring
        logic sel;
        assign sel = wr_acc && ring_hit && (ring_idx == 2'(r));
        tctx_ring #(.NPRIO(NPRIO), .PW(PW), .CNT_W(CNT_W)) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .lim_we    (sel && (boff == 4'd1) && req_own),
            .lim_wd    (req_wdata[PW-1:0]),
            .set_we    (sel && (boff == 4'd2)),
            .set_wd    (req_wdata[NPRIO-1:0]),
            .post      (post_valid && (post_ring == 2'(r))),
            .post_prio (post_prio),
            .ack       (ack_v[r]),
            .gate      ((r == RING_POOL) ? pool_word[DATA_W-1] : 1'b1),
            .limit     (limit_v[r]),
            .pend_set  (pend_v[r]),
            .top_prio  (top_v[r]),
            .ack_cnt   (cnt_v[r]),
            .raise     (raise_v[r])
        );
    end

    assign exc_o = raise_v;

    // Read data selection
    always_comb begin
        rd_mux = '0;
        if (req_addr == A_ACK) begin
            if (raise_v[RING_PHYS])
                rd_mux[15:0] = {XT_PHYS, 6'd0, top_v[RING_PHYS]};
            else if (raise_v[RING_POOL])
                rd_mux[15:0] = {XT_POOL, 6'd0, top_v[RING_POOL]};
            else
                rd_mux[15:0] = {XT_NONE, 6'd0, limit_v[RING_PHYS]};
        end else if (req_addr == A_PULL || req_addr == A_POOL) begin
            rd_mux = pool_word;
        end else if (ring_hit) begin
            unique case (boff)
                4'd0: rd_mux[7:0] = raise_v[ring_idx] ?
                          ((ring_idx == 2'(RING_POOL)) ? 8'h40 : 8'h80) : 8'h00;
                4'd1: rd_mux[PW-1:0]    = limit_v[ring_idx];
                4'd2: rd_mux[NPRIO-1:0] = pend_v[ring_idx];
                4'd4: rd_mux[CNT_W-1:0] = cnt_v[ring_idx];
                4'd7: rd_mux[PW-1:0]    = top_v[ring_idx];
                default: rd_mux = '0;
            endcase
        end
    end

    // Pool context word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pool_word <= '0;
        end else if (wr_acc && req_addr == A_POOL) begin
            pool_word <= req_wdata;
        end else if (is_pull) begin
            pool_word[DATA_W-1] <= 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_acc) state_d = ST_RESP;   // IDLE_TO_RESP
            ST_RESP: state_d = ST_IDLE;               // RESP_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rsp_data <= '0;
        else if (rd_acc) rsp_data <= rd_mux;
    end

    // R2: a response lasts exactly one cycle
    p_rsp_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R2: port refuses requests while responding
    p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R4: pool line needs a valid context
    p_pool_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pool_word[DATA_W-1] |-> !exc_o[RING_POOL]);
    // R8: a pull leaves the context invalid
    p_pull_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_pull |=> !pool_word[DATA_W-1]);
    // R5: at most one ring is acknowledged at a time
    p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_v));
endmodule

// File: tb/tb_tctx_top.sv
module tb_tctx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_own = 1'b1;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        post_valid = 1'b0;
    logic [1:0]  post_ring = '0;
    logic [2:0]  post_prio = '0;
    logic [2:0]  exc_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tctx_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_own(req_own),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .post_valid(post_valid), .post_ring(post_ring), .post_prio(post_prio),
        .exc_o(exc_o)
    );

    // op: 0 write, 1 read-and-compare, 2 post (ring in addr, prio in data)
    localparam int NV = 40;
    localparam logic [77:0] VEC [NV] = '{
        {2'd1, 12'h031, 32'h0, 32'h00000000},  // R1 limit reset
        {2'd0, 12'h031, 32'hFF, 32'h0},
        {2'd1, 12'h037, 32'h0, 32'h000000FF},  // R3 empty
        {2'd2, 12'h002, 32'h5, 32'h0},
        {2'd1, 12'h032, 32'h0, 32'h00000020},  // R3 bit 5
        {2'd1, 12'h037, 32'h0, 32'h00000005},  // R3
        {2'd2, 12'h002, 32'h3, 32'h0},
        {2'd1, 12'h037, 32'h0, 32'h00000003},  // R3 lowest
        {2'd1, 12'h030, 32'h0, 32'h00000080},  // R4 status
        {2'd1, 12'h800, 32'h0, 32'h00008003},  // R5 phys ack
        {2'd1, 12'h031, 32'h0, 32'h00000003},  // R6 limit raised
        {2'd1, 12'h032, 32'h0, 32'h00000020},  // R6 bit cleared
        {2'd1, 12'h034, 32'h0, 32'h00000001},  // R6 count
        {2'd1, 12'h030, 32'h0, 32'h00000000},  // R4 quiet
        {2'd1, 12'h800, 32'h0, 32'h00000003},  // R5 empty ack
        {2'd0, 12'h031, 32'hFF, 32'h0},
        {2'd1, 12'h800, 32'h0, 32'h00008005},  // R5 second ack
        {2'd1, 12'h034, 32'h0, 32'h00000002},  // R6 count
        {2'd0, 12'h011, 32'h04, 32'h0},
        {2'd2, 12'h000, 32'h4, 32'h0},
        {2'd1, 12'h010, 32'h0, 32'h00000000},  // R4 equal stays quiet
        {2'd2, 12'h000, 32'h1, 32'h0},
        {2'd1, 12'h010, 32'h0, 32'h00000080},  // R4 OS status
        {2'd1, 12'h017, 32'h0, 32'h00000001},  // R3 OS pending
        {2'd0, 12'h028, 32'h80000042, 32'h0},
        {2'd1, 12'h028, 32'h0, 32'h80000042},  // R8 word
        {2'd0, 12'h021, 32'hFF, 32'h0},
        {2'd2, 12'h001, 32'h6, 32'h0},
        {2'd1, 12'h020, 32'h0, 32'h00000040},  // R4 pool status
        {2'd1, 12'h800, 32'h0, 32'h00004006},  // R5 pool ack
        {2'd1, 12'h021, 32'h0, 32'h00000006},  // R6 pool limit
        {2'd1, 12'h828, 32'h0, 32'h80000042},  // R8 pull
        {2'd1, 12'h028, 32'h0, 32'h00000042},  // R8 invalid after pull
        {2'd2, 12'h001, 32'h2, 32'h0},
        {2'd1, 12'h800, 32'h0, 32'h00000005},  // R5 pool gated
        {2'd1, 12'h020, 32'h0, 32'h00000000},  // R4 pool gated
        {2'd0, 12'h028, 32'h80000007, 32'h0},
        {2'd2, 12'h002, 32'h1, 32'h0},
        {2'd1, 12'h800, 32'h0, 32'h00008001},  // R5 phys wins
        {2'd1, 12'h800, 32'h0, 32'h00004002}   // R5 then pool
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mmio_wr(input logic [11:0] a, input logic [31:0] d, input logic own);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_own = own;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_own = 1'b1;
    endtask

    task automatic mmio_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        check("R2 ready low", {31'd0, req_ready}, 32'd0);
        d = rsp_data;
        @(posedge clk);
    endtask

    task automatic post(input logic [1:0] r, input logic [2:0] p);
        @(negedge clk);
        post_valid = 1'b1; post_ring = r; post_prio = p;
        @(posedge clk);
        @(negedge clk);
        post_valid = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 exc_o", {29'd0, exc_o}, 32'd0);
        check("R1 ready", {31'd0, req_ready}, 32'd1);
        mmio_rd(12'h028, d); check("R1 pool word", d, 32'd0);
        mmio_rd(12'h014, d); check("R1 OS count", d, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [11:0] a;
            logic [31:0] wd, ex;
            {op, a, wd, ex} = VEC[i];
            case (op)
                2'd0: mmio_wr(a, wd, 1'b1);
                2'd1: begin
                    mmio_rd(a, d);
                    check($sformatf("vector %0d (see table tag)", i), d, ex);
                end
                default: post(a[1:0], wd[2:0]);
            endcase
        end

        // R7: foreign window cannot move the limit (phys limit is 1 now)
        mmio_wr(12'h031, 32'hFF, 1'b0);
        mmio_rd(12'h031, d); check("R7 foreign limit write", d, 32'h01);
        // R7: pending set writable
        mmio_wr(12'h012, 32'h81, 1'b1);
        mmio_rd(12'h012, d); check("R7 pending write", d, 32'h81);
        // R4: OS line (limit 4, lowest pending 0)
        @(negedge clk);
        check("R4 exc_o OS", {31'd0, exc_o[0]}, 32'd1);
        // R9: reserved bytes and read-only bytes
        mmio_rd(12'h013, d); check("R9 reserved 3", d, 32'd0);
        mmio_rd(12'h016, d); check("R9 reserved 6", d, 32'd0);
        mmio_wr(12'h014, 32'h55, 1'b1);
        mmio_rd(12'h014, d); check("R9 count write ignored", d, 32'd0);
        mmio_wr(12'h017, 32'h02, 1'b1);
        mmio_rd(12'h017, d); check("R9 pending prio write ignored", d, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule